// File: doc/BRIEF.md
# Shared-pin GPIO bank with per-pin interrupt triggers

This block manages a bank of general-purpose pins, each of which is shared with a peripheral function. A per-pin routing bit decides whether the pad is driven by the peripheral's own enable and data or by the GPIO logic. Under GPIO control, a pin is an output, a plain input, or an input that raises an interrupt. The pad inputs are brought into the clock domain through a two-stage synchronizer. They are then offered to the peripheral, to a readable input register and to the interrupt detectors.

Each interrupt pin uses one of four triggers: rising edge, falling edge, low level or high level. Edge events set sticky status bits, and software clears them by writing ones. Level status bits follow the synchronized pin while the pin is armed. The enabled status bits are ORed into a single registered interrupt line. Configuration goes through a simple register port, with a write strobe and a read strobe that returns data one cycle later.

Top module: `gpio_mux_irq`

## Requirements
- R1: After reset every pin is a GPIO input with interrupts off: pad_oe and irq are 0, and every register reads 0.
- R2: Register 0 (route) bit i = 1 passes per_oe[i] and per_out[i] to pad_oe[i] and pad_out[i] one cycle later. Bit i = 0 hands the pad to the GPIO logic.
- R3: Under GPIO control, register 1 (direction) bit i = 1 makes pin i an output: pad_oe[i] = 1 and pad_out[i] follows register 2 (output data), one cycle after a write.
- R4: Register 6 (input, read-only) and per_in return pad_in after the two-flop synchronizer, within three cycles of a pad change.
- R5: A pin's trigger code is {register 4 bit i, register 5 bit i}. Code 00 (rising edge) sets status bit i when the synchronized pin goes 0 to 1.
- R6: Code 01 (falling edge) sets status bit i when the synchronized pin goes 1 to 0.
- R7: Code 10 (low level) makes status bit i equal 1 exactly while the armed pin is low, and 0 when the pin is not armed.
- R8: Code 11 (high level) makes status bit i equal 1 exactly while the armed pin is high.
- R9: Writing register 7 (status) clears edge-mode status bits where the data bit is 1. Data bits of 0 have no effect, and level-mode bits are not changed by the write.
- R10: A pin is armed only when register 3 (interrupt enable) bit i = 1, its direction bit is 0 and its route bit is 0. Events on a pin that is not armed set no status.
- R11: irq equals the OR of (status AND interrupt enable), registered one cycle after the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is valid the next cycle |
| addr | input | 3 | Register index |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Registered read data |
| pad_in | input | NPIN | Pad input levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_out | output | NPIN | Pad output data |
| per_oe | input | NPIN | Peripheral output enables |
| per_out | input | NPIN | Peripheral output data |
| per_in | output | NPIN | Synchronized pad levels for the peripheral |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the pad routing against the route, direction and peripheral inputs of the cycle before. They also check that the interrupt line equals the OR of the enabled status bits, that status never rises on a pin that is not armed, and that level-mode status drops when its pin is disarmed. Only the bench's scenarios can show the sensitivity to edge direction, the sticky and write-one-to-clear behaviour, and the matching of level polarity against actual pad sequences. The bench runs these through directed trigger patterns and random mixes of configuration writes, pad changes and clears.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_ROUTE = 3'd0,
    REG_DIR   = 3'd1,
    REG_DOUT  = 3'd2,
    REG_IEN   = 3'd3,
    REG_TLVL  = 3'd4,
    REG_TPOL  = 3'd5,
    REG_DIN   = 3'd6,
    REG_STAT  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_mux_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NPIN-1:0]   din,
  input  logic [NPIN-1:0]   status,
  output logic [NPIN-1:0]   route,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   ien,
  output logic [NPIN-1:0]   tlvl,
  output logic [NPIN-1:0]   tpol,
  output logic [NPIN-1:0]   stat_clr,
  output logic [NPIN-1:0]   rdata
);
  logic [NPIN-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      route <= '0;
      dir   <= '0;
      dout  <= '0;
      ien   <= '0;
      tlvl  <= '0;
      tpol  <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_ROUTE: route <= wdata;
        REG_DIR:   dir   <= wdata;
        REG_DOUT:  dout  <= wdata;
        REG_IEN:   ien   <= wdata;
        REG_TLVL:  tlvl  <= wdata;
        REG_TPOL:  tpol  <= wdata;
        default:   ;
      endcase
    end
  end

  assign stat_clr = (wr_en && addr == REG_STAT) ? wdata : '0;

  always_comb begin
    case (addr)
      REG_ROUTE: rd_mux = route;
      REG_DIR:   rd_mux = dir;
      REG_DOUT:  rd_mux = dout;
      REG_IEN:   rd_mux = ien;
      REG_TLVL:  rd_mux = tlvl;
      REG_TPOL:  rd_mux = tpol;
      REG_DIN:   rd_mux = din;
      default:   rd_mux = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] din,
  input  logic [NPIN-1:0] route,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] ien,
  input  logic [NPIN-1:0] tlvl,
  input  logic [NPIN-1:0] tpol,
  input  logic [NPIN-1:0] stat_clr,
  output logic [NPIN-1:0] armed,
  output logic [NPIN-1:0] status,
  output logic            irq
);
  logic [NPIN-1:0] din_q;
  logic [NPIN-1:0] rise;
  logic [NPIN-1:0] fall;
  logic [NPIN-1:0] stat_nxt;

  assign armed = ien & ~dir & ~route;
  assign rise  = din & ~din_q;
  assign fall  = ~din & din_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      if (tlvl[i]) begin
        stat_nxt[i] = armed[i] & ~(din[i] ^ tpol[i]);
      end else begin
        stat_nxt[i] = (status[i] & ~stat_clr[i])
                    | (armed[i] & (tpol[i] ? fall[i] : rise[i]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q  <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      din_q  <= din;
      status <= stat_nxt;
      irq    <= |(status & ien);
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] route,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] dout,
  input  logic [NPIN-1:0] per_oe,
  input  logic [NPIN-1:0] per_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else if (route[i]) begin
        pad_oe[i]  <= per_oe[i];
        pad_out[i] <= per_out[i];
      end else begin
        pad_oe[i]  <= dir[i];
        pad_out[i] <= dout[i];
      end
    end
  end
endmodule

// File: rtl/gpio_mux_irq.sv
module gpio_mux_irq
  import gpio_mux_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  input  logic [NPIN-1:0]   per_oe,
  input  logic [NPIN-1:0]   per_out,
  output logic [NPIN-1:0]   per_in,
  output logic              irq
);
  logic [NPIN-1:0] din_s;
  logic [NPIN-1:0] cfg_route, cfg_dir, cfg_dout, cfg_ien, cfg_tlvl, cfg_tpol;
  logic [NPIN-1:0] stat_clr, irq_status, pin_armed;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(din_s)
  );

  gpio_cfg_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .din(din_s), .status(irq_status),
    .route(cfg_route), .dir(cfg_dir), .dout(cfg_dout), .ien(cfg_ien),
    .tlvl(cfg_tlvl), .tpol(cfg_tpol), .stat_clr(stat_clr), .rdata(rdata)
  );

  gpio_irq_unit #(.NPIN(NPIN)) u_irq (
    .clk(clk), .rst(rst), .din(din_s), .route(cfg_route), .dir(cfg_dir),
    .ien(cfg_ien), .tlvl(cfg_tlvl), .tpol(cfg_tpol), .stat_clr(stat_clr),
    .armed(pin_armed), .status(irq_status), .irq(irq)
  );

  gpio_pad_mux #(.NPIN(NPIN)) u_pad (
    .clk(clk), .rst(rst), .route(cfg_route), .dir(cfg_dir), .dout(cfg_dout),
    .per_oe(per_oe), .per_out(per_out), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  assign per_in = din_s;
endmodule

// File: rtl/gpio_mux_irq_chk.sv
module gpio_mux_irq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            irq,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] per_oe,
  input logic [NPIN-1:0] route,
  input logic [NPIN-1:0] dir,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] tlvl,
  input logic [NPIN-1:0] armed,
  input logic [NPIN-1:0] status
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == 1'b0 && pad_oe == '0)); // R1

  AST_PAD_ROUTE: assert property (@(posedge clk) disable iff (rst)
    pad_oe == $past((route & per_oe) | (~route & dir))); // R2

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & ien))); // R11

  AST_NO_SET_DISARMED: assert property (@(posedge clk) disable iff (rst)
    (status & ~$past(status) & ~$past(armed)) == '0); // R10

  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (rst)
    (status & $past(tlvl) & ~$past(armed)) == '0); // R7
endmodule

bind gpio_mux_irq gpio_mux_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .pad_oe(pad_oe), .per_oe(per_oe),
  .route(cfg_route), .dir(cfg_dir), .ien(cfg_ien), .tlvl(cfg_tlvl),
  .armed(pin_armed), .status(irq_status)
);

// File: tb/test_gpio_mux_irq.sv
module test_gpio_mux_irq;
  localparam int NPIN = 8;
  typedef logic [NPIN-1:0] vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  vec_t wdata = '0, rdata, pad_in = '0, pad_oe, pad_out;
  vec_t per_oe = '0, per_out = '0, per_in;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  vec_t m_route = '0, m_dir = '0, m_dout = '0, m_ien = '0, m_tlvl = '0, m_tpol = '0;
  vec_t m_stat = '0, cur_pad = '0;

  always #10 clk = ~clk;

  gpio_mux_irq #(.NPIN(NPIN)) i_gpio_mux_irq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .per_oe(per_oe), .per_out(per_out), .per_in(per_in),
    .irq(irq)
  );

  function automatic vec_t armed_f();
    return m_ien & ~m_dir & ~m_route;
  endfunction

  function automatic vec_t level_f();
    return armed_f() & m_tlvl & ~(cur_pad ^ m_tpol);
  endfunction

  function automatic vec_t exp_oe();
    return (m_route & per_oe) | (~m_route & m_dir);
  endfunction

  function automatic vec_t exp_out();
    return (m_route & per_out) | (~m_route & m_dout);
  endfunction

  task automatic chk(input string tag, input vec_t act, input vec_t exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input vec_t d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_route = d;
      3'd1: m_dir   = d;
      3'd2: m_dout  = d;
      3'd3: m_ien   = d;
      3'd4: m_tlvl  = d;
      3'd5: m_tpol  = d;
      3'd7: m_stat  = m_stat & ~(d & ~m_tlvl);
      default: ;
    endcase
    m_stat = (m_stat & ~m_tlvl) | level_f();
    idle(3);
  endtask

  task automatic rd(input logic [2:0] a, output vec_t d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pad(input vec_t nv);
    vec_t rise, fall, ev;
    rise = nv & ~cur_pad;
    fall = ~nv & cur_pad;
    ev = armed_f() & ~m_tlvl & ((m_tpol & fall) | (~m_tpol & rise));
    @(negedge clk);
    pad_in = nv;
    cur_pad = nv;
    m_stat = ((m_stat | ev) & ~m_tlvl) | level_f();
    idle(5);
  endtask

  task automatic check_all();
    vec_t d;
    rd(3'd7, d);
    chk("R5 R6 R7 R8 R9 R10 status", d, m_stat);
    rd(3'd6, d);
    chk("R4 input reg", d, cur_pad);
    chk("R4 per_in", per_in, cur_pad);
    chk("R11 irq", vec_t'(irq), vec_t'(|(m_stat & m_ien)));
    chk("R2 R3 pad_oe", pad_oe, exp_oe());
    chk("R2 R3 pad_out", pad_out, exp_out());
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t d;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 irq", vec_t'(irq), '0);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 register", d, '0);
    end

    // R3 GPIO outputs
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hA5);
    chk("R3 pad_oe", pad_oe, 8'hFF);
    chk("R3 pad_out", pad_out, 8'hA5);

    // R2 peripheral routing on low nibble
    per_oe = 8'h3C; per_out = 8'h66;
    wr(3'd0, 8'h0F);
    chk("R2 pad_oe", pad_oe, 8'hFC);
    chk("R2 pad_out", pad_out, 8'hA6);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R4 synchronized input
    set_pad(8'h5A);
    rd(3'd6, d);
    chk("R4 input reg", d, 8'h5A);
    chk("R4 per_in", per_in, 8'h5A);
    set_pad(8'h00);

    // trigger mix: pins 0-3 edge (rise,fall,rise,fall), 4-7 level (low,high,low,high)
    wr(3'd4, 8'hF0);
    wr(3'd5, 8'hAA);
    wr(3'd3, 8'hFF);
    rd(3'd7, d);
    chk("R7 low level with pad low", d, 8'h50);
    chk("R11 irq from level", vec_t'(irq), 8'h01);
    set_pad(8'hFF);
    rd(3'd7, d);
    chk("R5 R8 rising edge and high level", d, 8'hA5);
    set_pad(8'h00);
    rd(3'd7, d);
    chk("R6 R7 falling edge sticky", d, 8'h5F);
    wr(3'd7, 8'h03);
    rd(3'd7, d);
    chk("R9 clear edge bits 0,1", d, 8'h5C);
    wr(3'd7, 8'hF0);
    rd(3'd7, d);
    chk("R9 level bits untouched", d, 8'h5C);
    wr(3'd7, 8'hFF);

    // R10 disarmed pins ignore edges
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h02);
    set_pad(8'h03);
    set_pad(8'h00);
    rd(3'd7, d);
    chk("R10 disarmed pins", d, 8'h50);

    // R11 masking: disable pins 4..7, edge bits remain but masked
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    set_pad(8'h01);
    wr(3'd3, 8'h0E);
    rd(3'd7, d);
    chk("R11 status kept while masked", d, 8'h01);
    chk("R11 irq masked", vec_t'(irq), 8'h00);
    check_all();

    // random mix
    for (int it = 0; it < 250; it++) begin
      int unsigned op;
      op = $urandom_range(0, 3);
      per_oe = vec_t'($urandom);
      per_out = vec_t'($urandom);
      case (op)
        0: wr(3'($urandom_range(0, 5)), vec_t'($urandom));
        1: set_pad(vec_t'($urandom));
        2: wr(3'd7, vec_t'($urandom));
        default: begin
          wr(3'd0, vec_t'($urandom) & vec_t'($urandom));
          set_pad(vec_t'($urandom));
        end
      endcase
      idle(1);
      check_all();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule